// File: doc/BRIEF.md
# Paged Configuration Register Bank

A byte-wide configuration register file for one channel of a serial-video line interface. A serial slave front end (SPI or SMBus) drives it through a plain address/data port with separate write and read strobes. Writes commit on the rising clock edge. Read data is combinational and is zero whenever the read strobe is low.

The bank holds two pages, and both use 8-bit addresses. The shared page holds the version and identity bytes and a control byte at 0xFF. The control byte answers in both pages and carries the page select and the status-pin source select. The channel page holds the equalizer, signal-detect and interrupt-mask bytes, the routing/adapt byte, two live status bytes fed from input pins, and a self-clearing soft reset. That soft reset returns only the channel page to its defaults.

The routing field is decoded into an input select and two output enables. The adapt field is exported together with a flag for unsupported codes.

Top module: `cfg_page_bank`

## Requirements
- R1: After rst_ni the shared page reads 0xF0 = 0x01, 0xF1 = 0x60 and 0xFF = 0x00.
- R2: Address 0xFF reaches the control byte in either page. Control bit 2 = 1 routes every other address to the channel page, and 0 routes it to the shared page. Control bits other than 5 and 2 ignore writes and read 0.
- R3: status_o equals irq_i when control bit 5 is 1, and sigdet_i when it is 0.
- R4: Writing a byte with bit 2 set to channel address 0x00 returns every channel register to its default at the next clock edge. The bit then reads 0 again, and shared-page registers (page select included) keep their values. All other bits of channel 0x00 read 0.
- R5: After rst_ni the channel page reads 0x03 = 0x80, 0x13 = 0x90, 0x2D = 0x88, and 0x0D, 0x31, 0x56 = 0x00.
- R6: Channel 0x31 bits [1:0] drive the routing outputs (in_sel_o: 0 = input 0, 1 = input 1): 00 = input 0 to both outputs, 01 = input 0 to output 0 only, 10 = input 1 to output 1 only, 11 = input 1 to both outputs.
- R7: Channel 0x31 bits [6:5] drive adapt_mode_o (00 normal, 01 test). adapt_bad_o is 1 exactly when the field is 10 or 11.
- R8: Channel 0x01 reads {6'b0, los_i[1], los_i[0]}, where bit 1 is input 1 and bit 0 is input 0. Channel 0x02 reads 0x18 when lock_i = 1 and 0x00 otherwise. Writes to both bytes have no effect.
- R9: Writable bits are all of 0x03, 0x2D, 0xF0 and 0xF1, bit 0 of 0x0D, bits 6,5,1 of 0x13, bits 6,5,1,0 of 0x31 and bits 6..0 of 0x56. All other bits ignore writes and read their reset value, so 0x13 written with 0xFF reads 0xF2.
- R10: A read of an unmapped address in the active page returns 0x00 and changes no state. rdata_o is 0x00 while rd_en_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| los_i | input | 2 | Loss-of-signal flags, [1] input 1, [0] input 0 |
| lock_i | input | 1 | Recovered-clock lock indication |
| irq_i | input | 1 | Aggregated interrupt from outside |
| sigdet_i | input | 1 | Signal detect of the selected input |
| status_o | output | 1 | Status pin source after selection |
| in_sel_o | output | 1 | Selected input, 0 or 1 |
| out0_en_o | output | 1 | Output 0 enable |
| out1_en_o | output | 1 | Output 1 enable |
| adapt_mode_o | output | 2 | Adapt mode field |
| adapt_bad_o | output | 1 | Adapt mode field holds an unsupported code |

## Verification
Random mixes of reads and writes are applied over mapped and unmapped addresses in both pages, with the page select flipping mid-stream. This separates correct page steering from address decoding that ignores the page. All-ones and all-zeros writes to masked registers show whether reserved bits are really held. A soft reset issued while the channel page holds non-default data, and while the shared page holds changed identity bytes, shows whether the clear is limited to the channel page. A sweep of all four routing codes and all four adapt codes tells each decode apart. Toggling the loss, lock, interrupt and signal-detect inputs shows the live status bytes and the pin select tracking their sources.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;
  typedef logic [7:0] byte_t;

  localparam int     AW          = 8;
  localparam byte_t  CTRL_ADDR   = 8'hFF;
  localparam int     PAGE_BIT    = 2;
  localparam int     STSEL_BIT   = 5;
  localparam int     SRST_BIT    = 2;
  localparam byte_t  CH_CTRL     = 8'h00;
  localparam byte_t  CH_LOS      = 8'h01;
  localparam byte_t  CH_LOCK     = 8'h02;
  localparam int     LOCK_LSB    = 3;

  // shared page: version, identity, control
  localparam int     NUM_SH = 3;
  localparam byte_t  SH_ADDR [NUM_SH] = '{8'hF0, 8'hF1, 8'hFF};
  localparam byte_t  SH_RST  [NUM_SH] = '{8'h01, 8'h60, 8'h00};
  localparam byte_t  SH_MASK [NUM_SH] = '{8'hFF, 8'hFF, 8'h24};
  localparam int     SH_CTRL_IDX = 2;

  // channel page: eq boost, low-rate eq, detect cfg, eq ctrl, route, irq mask
  localparam int     NUM_CH = 6;
  localparam byte_t  CH_ADDR [NUM_CH] = '{8'h03, 8'h0D, 8'h13, 8'h2D, 8'h31, 8'h56};
  localparam byte_t  CH_RST  [NUM_CH] = '{8'h80, 8'h00, 8'h90, 8'h88, 8'h00, 8'h00};
  localparam byte_t  CH_MASK [NUM_CH] = '{8'hFF, 8'h01, 8'h62, 8'hFF, 8'h63, 8'h7F};
  localparam int     ROUTE_IDX = 4;
  localparam int     ADAPT_LSB = 5;
endpackage

// File: rtl/cfg_rw_reg.sv
module cfg_rw_reg
  import cfg_bank_pkg::*;
#(
  parameter byte_t RST  = 8'h00,
  parameter byte_t MASK = 8'hFF
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clr_i,
  input  logic  we_i,
  input  byte_t wdata_i,
  output byte_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= RST;
    else if (clr_i)  q_o <= RST;
    else if (we_i)   q_o <= (wdata_i & MASK) | (RST & ~MASK);
  end
endmodule

// File: rtl/cfg_shared_page.sv
module cfg_shared_page
  import cfg_bank_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  byte_t         wdata_i,
  output byte_t         rdata_o,
  output byte_t         ctrl_o
);
  byte_t q [NUM_SH];

  for (genvar g = 0; g < NUM_SH; g++) begin : g_reg
    cfg_rw_reg #(.RST(SH_RST[g]), .MASK(SH_MASK[g])) u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (1'b0),
      .we_i    (we_i && (addr_i == SH_ADDR[g])),
      .wdata_i (wdata_i),
      .q_o     (q[g])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_SH; i++)
      if (addr_i == SH_ADDR[i]) rdata_o = q[i];
  end

  assign ctrl_o = q[SH_CTRL_IDX];
endmodule

// File: rtl/cfg_chan_page.sv
module cfg_chan_page
  import cfg_bank_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  byte_t         wdata_i,
  input  logic [1:0]    los_i,
  input  logic          lock_i,
  output byte_t         rdata_o,
  output byte_t         route_o
);
  logic  srst_q;
  byte_t q [NUM_CH];

  // pulse: set by the write, clears the page on the following edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) srst_q <= 1'b0;
    else         srst_q <= we_i && (addr_i == CH_CTRL) && wdata_i[SRST_BIT];
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_reg
    cfg_rw_reg #(.RST(CH_RST[g]), .MASK(CH_MASK[g])) u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (srst_q),
      .we_i    (we_i && (addr_i == CH_ADDR[g])),
      .wdata_i (wdata_i),
      .q_o     (q[g])
    );
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      CH_CTRL: rdata_o[SRST_BIT] = srst_q;
      CH_LOS:  rdata_o[1:0] = los_i;
      CH_LOCK: rdata_o[LOCK_LSB+:2] = {2{lock_i}};
      default: begin
        for (int i = 0; i < NUM_CH; i++)
          if (addr_i == CH_ADDR[i]) rdata_o = q[i];
      end
    endcase
  end

  assign route_o = q[ROUTE_IDX];
endmodule

// File: rtl/cfg_route_dec.sv
module cfg_route_dec
  import cfg_bank_pkg::*;
(
  input  byte_t      route_i,
  output logic       in_sel_o,
  output logic       out0_en_o,
  output logic       out1_en_o,
  output logic [1:0] adapt_mode_o,
  output logic       adapt_bad_o
);
  logic [1:0] sel;
  assign sel = route_i[1:0];

  always_comb begin
    unique case (sel)
      2'b00:   {in_sel_o, out0_en_o, out1_en_o} = 3'b011;
      2'b01:   {in_sel_o, out0_en_o, out1_en_o} = 3'b010;
      2'b10:   {in_sel_o, out0_en_o, out1_en_o} = 3'b101;
      default: {in_sel_o, out0_en_o, out1_en_o} = 3'b111;
    endcase
  end

  assign adapt_mode_o = route_i[ADAPT_LSB+:2];
  assign adapt_bad_o  = route_i[ADAPT_LSB+1];
endmodule

// File: rtl/cfg_page_bank.sv
module cfg_page_bank
  import cfg_bank_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic [1:0] los_i,
  input  logic       lock_i,
  input  logic       irq_i,
  input  logic       sigdet_i,
  output logic       status_o,
  output logic       in_sel_o,
  output logic       out0_en_o,
  output logic       out1_en_o,
  output logic [1:0] adapt_mode_o,
  output logic       adapt_bad_o
);
  byte_t sh_rdata, ch_rdata, ctrl, route;
  logic  ch_page, to_shared;

  assign ch_page   = ctrl[PAGE_BIT];
  assign to_shared = (addr_i == CTRL_ADDR) || !ch_page;

  cfg_shared_page u_shared (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i && to_shared),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (sh_rdata),
    .ctrl_o  (ctrl)
  );

  cfg_chan_page u_chan (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i && !to_shared),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .los_i   (los_i),
    .lock_i  (lock_i),
    .rdata_o (ch_rdata),
    .route_o (route)
  );

  cfg_route_dec u_dec (
    .route_i      (route),
    .in_sel_o     (in_sel_o),
    .out0_en_o    (out0_en_o),
    .out1_en_o    (out1_en_o),
    .adapt_mode_o (adapt_mode_o),
    .adapt_bad_o  (adapt_bad_o)
  );

  assign rdata_o  = !rd_en_i ? 8'h00 : (to_shared ? sh_rdata : ch_rdata);
  assign status_o = ctrl[STSEL_BIT] ? irq_i : sigdet_i;
endmodule

// File: rtl/cfg_page_bank_chk.sv
module cfg_page_bank_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic       rd_en_i,
  input logic [7:0] addr_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic [1:0] los_i,
  input logic       lock_i,
  input logic       irq_i,
  input logic       sigdet_i,
  input logic       status_o,
  input logic       in_sel_o,
  input logic       out0_en_o,
  input logic       out1_en_o,
  input logic [1:0] adapt_mode_o,
  input logic       adapt_bad_o
);
  // shadow of page and pin select, tracked from port writes
  logic sh_page, sh_stsel;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_page  <= 1'b0;
      sh_stsel <= 1'b0;
    end else if (wr_en_i && addr_i == 8'hFF) begin
      sh_page  <= wdata_i[2];
      sh_stsel <= wdata_i[5];
    end
  end

  p_idle_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> rdata_o == 8'h00);

  p_unmapped_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && sh_page && addr_i == 8'h50) |-> rdata_o == 8'h00);

  p_status_sel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o == (sh_stsel ? irq_i : sigdet_i));

  p_lock_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && sh_page && addr_i == 8'h02) |-> rdata_o == {3'b0, lock_i, lock_i, 3'b0});

  p_los_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && sh_page && addr_i == 8'h01) |-> rdata_o == {6'b0, los_i});

  p_route_any_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out0_en_o || out1_en_o) && (in_sel_o ? out1_en_o : out0_en_o));

  p_adapt_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adapt_bad_o == (adapt_mode_o == 2'b10 || adapt_mode_o == 2'b11));
endmodule

bind cfg_page_bank cfg_page_bank_chk u_chk (.*);

// File: tb/sim_cfg_page_bank.sv
`timescale 1ns/1ps
module sim_cfg_page_bank;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr_en = 0, rd_en = 0;
  logic [7:0] addr = 0, wdata = 0, rdata;
  logic [1:0] los = 0;
  logic       lock = 0, irq = 0, sigdet = 0;
  logic       status, in_sel, out0_en, out1_en, adapt_bad;
  logic [1:0] adapt_mode;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] m_sh [256];
  logic [7:0] m_ch [256];

  always #5 clk = ~clk;

  cfg_page_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .los_i(los),
    .lock_i(lock), .irq_i(irq), .sigdet_i(sigdet), .status_o(status),
    .in_sel_o(in_sel), .out0_en_o(out0_en), .out1_en_o(out1_en),
    .adapt_mode_o(adapt_mode), .adapt_bad_o(adapt_bad)
  );

  function automatic bit sh_map(input logic [7:0] a);
    return a == 8'hF0 || a == 8'hF1 || a == 8'hFF;
  endfunction
  function automatic bit ch_map(input logic [7:0] a);
    return a == 8'h03 || a == 8'h0D || a == 8'h13 || a == 8'h2D || a == 8'h31 || a == 8'h56;
  endfunction
  function automatic logic [7:0] rst_of(input bit ch, input logic [7:0] a);
    if (!ch) return a == 8'hF0 ? 8'h01 : a == 8'hF1 ? 8'h60 : 8'h00;
    case (a)
      8'h03: return 8'h80;
      8'h13: return 8'h90;
      8'h2D: return 8'h88;
      default: return 8'h00;
    endcase
  endfunction
  function automatic logic [7:0] mask_of(input bit ch, input logic [7:0] a);
    if (!ch) return a == 8'hFF ? 8'h24 : 8'hFF;
    case (a)
      8'h0D: return 8'h01;
      8'h13: return 8'h62;
      8'h31: return 8'h63;
      8'h56: return 8'h7F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic void model_chan_reset();
    for (int i = 0; i < 256; i++) m_ch[i] = rst_of(1, 8'(i));
  endfunction

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    if (a == 8'hFF) return m_sh[8'hFF];
    if (m_sh[8'hFF][2]) begin
      if (a == 8'h01) return {6'b0, los};
      if (a == 8'h02) return lock ? 8'h18 : 8'h00;
      return ch_map(a) ? m_ch[a] : 8'h00;
    end
    return sh_map(a) ? m_sh[a] : 8'h00;
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] w);
    bit clr = 0;
    @(negedge clk);
    rd_en = 0; wr_en = 1; addr = a; wdata = w;
    @(negedge clk);
    wr_en = 0;
    if (a == 8'hFF || !m_sh[8'hFF][2]) begin
      if (sh_map(a)) m_sh[a] = (w & mask_of(0, a)) | (rst_of(0, a) & ~mask_of(0, a));
    end else if (a == 8'h00) begin
      clr = w[2];
    end else if (ch_map(a)) begin
      m_ch[a] = (w & mask_of(1, a)) | (rst_of(1, a) & ~mask_of(1, a));
    end
    if (clr) begin
      @(negedge clk);
      model_chan_reset();
    end
  endtask

  task automatic do_read(input string req, input logic [7:0] a);
    @(negedge clk);
    wr_en = 0; rd_en = 1; addr = a;
    #1 chk(req, rdata, exp_read(a));
    #1 rd_en = 0;
  endtask

  task automatic chk_route();
    logic [1:0] r = m_ch[8'h31][1:0];
    logic [1:0] m = m_ch[8'h31][6:5];
    chk("R6 in_sel", {7'b0, in_sel}, {7'b0, r[1]});
    chk("R6 out0_en", {7'b0, out0_en}, {7'b0, r != 2'b10});
    chk("R6 out1_en", {7'b0, out1_en}, {7'b0, r != 2'b01});
    chk("R7 adapt_mode", {6'b0, adapt_mode}, {6'b0, m});
    chk("R7 adapt_bad", {7'b0, adapt_bad}, {7'b0, m[1]});
  endtask

  task automatic set_page(input bit ch);
    do_write(8'hFF, {m_sh[8'hFF][7:3], ch, m_sh[8'hFF][1:0]});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] pool [10] = '{8'h03, 8'h0D, 8'h13, 8'h2D, 8'h31, 8'h56, 8'h01, 8'h02, 8'hF0, 8'hF1};
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) m_sh[i] = rst_of(0, 8'(i));
    model_chan_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 shared reset values, R10 idle read
    do_read("R1 ver", 8'hF0);
    do_read("R1 id", 8'hF1);
    do_read("R1 ctrl", 8'hFF);
    @(negedge clk); #1 chk("R10 idle", rdata, 8'h00);
    do_read("R10 unmapped shared", 8'h50);

    // R5 channel reset values
    set_page(1);
    do_read("R2 ctrl page", 8'hFF);
    foreach (pool[k]) do_read("R5 chan reset", pool[k]);
    chk_route();

    // R9 masks
    do_write(8'h13, 8'hFF); do_read("R9 0x13 all ones", 8'h13);
    do_write(8'h13, 8'h00); do_read("R9 0x13 all zeros", 8'h13);
    do_write(8'h0D, 8'hFE); do_read("R9 0x0D", 8'h0D);
    do_write(8'h56, 8'hFF); do_read("R9 0x56", 8'h56);
    do_write(8'h01, 8'hFF); do_write(8'h02, 8'hFF);
    do_read("R8 los ro", 8'h01); do_read("R8 lock ro", 8'h02);
    do_read("R10 unmapped chan", 8'h50);
    do_read("R4 ctrl idle", 8'h00);

    // R8 live status
    for (int v = 0; v < 8; v++) begin
      los = v[1:0]; lock = v[2];
      do_read("R8 los", 8'h01);
      do_read("R8 lock", 8'h02);
    end

    // R6 / R7 decode sweep
    for (int v = 0; v < 16; v++) begin
      do_write(8'h31, {1'b0, v[3:2], 3'b0, v[1:0]});
      chk_route();
    end

    // R3 status pin select
    do_write(8'hFF, 8'hFF);
    do_read("R2 ctrl mask", 8'hFF);
    for (int v = 0; v < 4; v++) begin
      irq = v[0]; sigdet = v[1]; #1;
      chk("R3 irq sel", {7'b0, status}, {7'b0, irq});
    end
    do_write(8'hFF, 8'h04);
    for (int v = 0; v < 4; v++) begin
      irq = v[0]; sigdet = v[1]; #1;
      chk("R3 sigdet sel", {7'b0, status}, {7'b0, sigdet});
    end

    // R2 page isolation: shared writes do not touch channel
    set_page(0);
    do_write(8'hF1, 8'hA5);
    do_write(8'h03, 8'h11);
    do_read("R2 shared id", 8'hF1);
    do_read("R2 shared hides chan", 8'h03);
    set_page(1);
    do_read("R2 chan eq", 8'h03);

    // R4 soft reset limited to channel page
    do_write(8'h03, 8'h3C); do_write(8'h2D, 8'h00); do_write(8'h31, 8'h62);
    do_write(8'h00, 8'h04);
    foreach (pool[k]) do_read("R4 after soft reset", pool[k]);
    do_read("R4 ctrl cleared", 8'h00);
    do_read("R4 page kept", 8'hFF);
    chk_route();
    set_page(0);
    do_read("R4 shared kept", 8'hF1);
    set_page(1);

    // random mix
    for (int n = 0; n < 600; n++) begin
      int op = $urandom_range(0, 9);
      logic [7:0] a = ($urandom_range(0, 7) == 0) ? 8'($urandom) : pool[$urandom_range(0, 9)];
      los = 2'($urandom); lock = 1'($urandom);
      if (op == 0)      set_page(1'($urandom));
      else if (op == 1) do_write(8'h00, 8'($urandom) | 8'h04);
      else if (op < 5)  do_write(a, 8'($urandom));
      else              do_read("R9 random read", a);
      if (n % 16 == 0) chk_route();
    end
    do_read("R10 random unmapped", 8'h77);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule